// File: doc/BRIEF.md
# Halfword Byte-Swapping DMA Transfer Path

This block moves data between a peripheral with a 16-bit bus and system memory. The peripheral posts a transfer request that carries an address, a byte count, a direction and a bypass flag. The block forms the memory address by ORing the request address with a programmed base value, then issues 16-bit beats to memory over a valid/ready handshake.

In swap mode (bypass flag low), the block clears bit 0 of both the address and the byte count. It then exchanges the two bytes of every halfword, in both directions. Swap-mode writes are split into bursts of at most 64 bytes. In bypass mode, data, address and length pass through unchanged, and a trailing odd byte uses a single-lane byte enable.

Write data is taken from the peripheral one halfword per accepted beat. Read data is returned to the peripheral one halfword per accepted beat. A one-cycle completion pulse follows the final beat.

Top module: `hwswap_dma_path`

## Requirements
- R1: The memory address of the first beat equals the request address bitwise-ORed with `baseAddr`, not added to it.
- R2: With `reqBypass`=1, address and length are used unchanged and data is not swapped. Byte lane 0 (`[7:0]`) maps to the lower byte address. The beat that covers a single remaining byte has `memByteEn`=2'b01; every other beat has 2'b11.
- R3: With `reqBypass`=0, bit 0 of the effective address and bit 0 of the length are cleared before the first beat.
- R4: With `reqBypass`=0, `memWdata` is `wrData` with its two bytes exchanged, and `rdData` is `memRdata` with its two bytes exchanged.
- R5: A swap-mode write is split into bursts of at most 64 bytes. `memBurstStart` is high on the first beat of each burst, and `memBurstBytes` gives that burst's byte count. Reads and bypass writes form a single burst covering the whole length.
- R6: Each accepted beat advances the memory address by 2 and consumes 2 bytes (1 for a final odd byte).
- R7: While `memValid` is high and `memReady` is low, the beat is held: `memValid` stays high and the address is unchanged on the next cycle.
- R8: A request whose effective length is zero issues no memory beat and still produces `done`.
- R9: `done` is high for exactly one cycle, in the cycle after the last beat is accepted. `reqReady` is low from acceptance until that `done` cycle.
- R10: In and after reset, `reqReady`=1, `memValid`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseAddr | input | ADDR_W | Programmed base ORed into every address |
| reqValid | input | 1 | Transfer request present |
| reqReady | output | 1 | Block idle, request will be accepted |
| reqWrite | input | 1 | 1 = peripheral to memory, 0 = memory to peripheral |
| reqBypass | input | 1 | 1 = no swap, no alignment |
| reqAddr | input | ADDR_W | Peripheral-side byte address |
| reqLen | input | LEN_W | Byte count |
| wrData | input | 16 | Peripheral halfword for the current write beat |
| wrTake | output | 1 | Current write halfword consumed |
| rdData | output | 16 | Halfword returned to the peripheral |
| rdValid | output | 1 | rdData valid this cycle |
| memValid | output | 1 | Beat request to memory |
| memReady | input | 1 | Memory accepts the beat |
| memWrite | output | 1 | Beat direction |
| memAddr | output | ADDR_W | Byte address of lane 0 |
| memByteEn | output | 2 | Lane enables |
| memBurstStart | output | 1 | First beat of a burst |
| memBurstBytes | output | LEN_W | Byte count of the burst starting at this beat |
| memWdata | output | 16 | Write data to memory |
| memRdata | input | 16 | Read data from memory, valid with memReady |
| done | output | 1 | Request complete pulse |

## Verification
Assertions check the following on every cycle: even addresses in swap mode, the 2-byte address step between beats, holding under back-pressure, the single-cycle completion pulse, and completion of zero-length requests. The 64-byte burst ceiling is also checked on every cycle. Only the bench scenarios can show the following: that the OR differs from an add when the base and the address share set bits, the actual lane exchange on written and read-back data, and the odd-byte enable at the end of a bypass transfer. The same holds for the exact burst boundaries of a long swapped write under stalls.

// File: rtl/hwswap_dma_pkg.sv
package hwswap_dma_pkg;
  typedef struct packed {
    logic load;
    logic step;
  } dpStrobe_t;
endpackage

// File: rtl/hwswap_dma_dp.sv
module hwswap_dma_dp
  import hwswap_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 12,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              reqWrite,
  input  logic              reqBypass,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [15:0]       wrData,
  input  logic [15:0]       memRdata,
  output logic              reqZero,
  output logic              lastBeat,
  output logic              isWrite,
  output logic [ADDR_W-1:0] curAddr,
  output logic [1:0]        byteEn,
  output logic              burstStart,
  output logic [LEN_W-1:0]  burstBytes,
  output logic [15:0]       outWdata,
  output logic [15:0]       outRdata
);
  localparam int BEATS = CHUNK_BYTES / 2;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [ADDR_W-1:0] addrQ;
  logic [LEN_W-1:0]  remQ;
  logic [BW-1:0]     beatQ;
  logic              firstQ, swapQ, writeQ;
  logic              chunked;

  wire [ADDR_W-1:0] addrMask = {{(ADDR_W-1){1'b1}}, reqBypass};
  wire [LEN_W-1:0]  lenMask  = {{(LEN_W-1){1'b1}}, reqBypass};

  assign reqZero = (reqLen & lenMask) == '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; remQ <= '0; beatQ <= '0;
      firstQ <= 1'b0; swapQ <= 1'b0; writeQ <= 1'b0;
    end else if (strobe.load) begin
      addrQ  <= (reqAddr | baseAddr) & addrMask;
      remQ   <= reqLen & lenMask;
      beatQ  <= '0;
      firstQ <= 1'b1;
      swapQ  <= !reqBypass;
      writeQ <= reqWrite;
    end else if (strobe.step) begin
      addrQ  <= addrQ + ADDR_W'(2);
      remQ   <= (remQ > LEN_W'(2)) ? remQ - LEN_W'(2) : '0;
      beatQ  <= (beatQ == BW'(BEATS - 1)) ? '0 : beatQ + BW'(1);
      firstQ <= 1'b0;
    end
  end

  assign chunked    = writeQ && swapQ;
  assign lastBeat   = remQ <= LEN_W'(2);
  assign isWrite    = writeQ;
  assign curAddr    = addrQ;
  assign byteEn     = (remQ == LEN_W'(1)) ? 2'b01 : 2'b11;
  assign burstStart = firstQ || (chunked && beatQ == '0);
  assign burstBytes = (chunked && remQ > LEN_W'(CHUNK_BYTES)) ? LEN_W'(CHUNK_BYTES) : remQ;
  assign outWdata   = swapQ ? {wrData[7:0], wrData[15:8]} : wrData;
  assign outRdata   = swapQ ? {memRdata[7:0], memRdata[15:8]} : memRdata;

  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && swapQ |-> !addrQ[0]);  // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && !lastBeat |=> addrQ == $past(addrQ) + ADDR_W'(2));  // R6
  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step && burstStart && chunked |-> burstBytes <= LEN_W'(CHUNK_BYTES));  // R5
endmodule

// File: rtl/hwswap_dma_ctrl.sv
module hwswap_dma_ctrl
  import hwswap_dma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqZero,
  input  logic      lastBeat,
  input  logic      memReady,
  output logic      reqReady,
  output logic      memValid,
  output logic      done,
  output dpStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;
  state_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stateD = reqZero ? ST_DONE : ST_RUN;
      end
      ST_RUN: if (memReady) begin
        strobe.step = 1'b1;
        if (lastBeat) stateD = ST_DONE;
      end
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = stateQ == ST_IDLE;
  assign memValid = stateQ == ST_RUN;
  assign done     = stateQ == ST_DONE;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done && reqReady);  // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && reqZero |=> done && !memValid);  // R8
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid);  // R7
endmodule

// File: rtl/hwswap_dma_path.sv
module hwswap_dma_path
  import hwswap_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LEN_W       = 12,
  parameter int CHUNK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic              reqBypass,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [15:0]       wrData,
  output logic              wrTake,
  output logic [15:0]       rdData,
  output logic              rdValid,
  output logic              memValid,
  input  logic              memReady,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memByteEn,
  output logic              memBurstStart,
  output logic [LEN_W-1:0]  memBurstBytes,
  output logic [15:0]       memWdata,
  input  logic [15:0]       memRdata,
  output logic              done
);
  dpStrobe_t strobe;
  logic reqZero, lastBeat;

  hwswap_dma_ctrl ctrl_i (
    .clk, .rstN, .reqValid, .reqZero, .lastBeat, .memReady,
    .reqReady, .memValid, .done, .strobe
  );

  hwswap_dma_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)) dp_i (
    .clk, .rstN, .strobe, .baseAddr, .reqWrite, .reqBypass, .reqAddr, .reqLen,
    .wrData, .memRdata, .reqZero, .lastBeat,
    .isWrite(memWrite), .curAddr(memAddr), .byteEn(memByteEn),
    .burstStart(memBurstStart), .burstBytes(memBurstBytes),
    .outWdata(memWdata), .outRdata(rdData)
  );

  assign wrTake  = memValid && memReady && memWrite;
  assign rdValid = memValid && memReady && !memWrite;

  AST_STALL_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> $stable(memAddr) && $stable(memByteEn));  // R7
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && !reqZero |=> !reqReady);  // R9
endmodule

// File: tb/hwswap_dma_path_tb.sv
module hwswap_dma_path_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] baseAddr = '0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqBypass = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [11:0] reqLen = '0;
  logic [15:0] wrData;
  logic wrTake, reqReady, rdValid, memValid, memWrite, memBurstStart, done;
  logic memReady = 1'b1;
  logic [15:0] rdData, memAddr, memWdata, memRdata;
  logic [1:0] memByteEn;
  logic [11:0] memBurstBytes;

  hwswap_dma_path dut_i (
    .clk, .rstN, .baseAddr, .reqValid, .reqReady, .reqWrite, .reqBypass,
    .reqAddr, .reqLen, .wrData, .wrTake, .rdData, .rdValid, .memValid,
    .memReady, .memWrite, .memAddr, .memByteEn, .memBurstStart,
    .memBurstBytes, .memWdata, .memRdata, .done
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mem [0:511];
  logic [15:0] srcData [0:127];
  logic [6:0] srcIdx = '0;
  logic srcClr = 1'b0, stallOn = 1'b0, zeroPending = 1'b0, doneExp = 1'b0;

  typedef struct {
    logic [15:0] addr; logic wr; logic [1:0] be; logic [15:0] data;
    logic bstart; logic [11:0] bbytes; logic last;
  } beat_t;
  beat_t expQ[$];

  assign wrData   = srcData[srcIdx];
  assign memRdata = {mem[9'(memAddr[8:0] + 9'd1)], mem[memAddr[8:0]]};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    memReady <= stallOn ? (cyc % 3 != 1) : 1'b1;
    if (srcClr) srcIdx <= '0; else if (wrTake) srcIdx <= srcIdx + 7'd1;
    if (memValid && memReady && memWrite) begin
      if (memByteEn[0]) mem[memAddr[8:0]] <= memWdata[7:0];
      if (memByteEn[1]) mem[9'(memAddr[8:0] + 9'd1)] <= memWdata[15:8];
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  logic stallPrev = 1'b0;
  logic [15:0] stallAddr = '0;
  always @(negedge clk) begin
    logic nextDone;
    beat_t e;
    nextDone = 1'b0;
    if (rstN) begin
      if (doneExp || done) chk(done === doneExp, "R9 done pulse", 32'(done), 32'(doneExp));
      if (stallPrev) begin
        chk(memValid === 1'b1, "R7 valid held", 32'(memValid), 1);
        chk(memAddr === stallAddr, "R7 addr held", 32'(memAddr), 32'(stallAddr));
      end
      stallPrev = memValid && !memReady;
      stallAddr = memAddr;
      if (memValid) begin
        if (reqReady !== 1'b0) chk(1'b0, "R9 reqReady while busy", 32'(reqReady), 0);
        if (memReady) begin
          if (expQ.size() == 0) chk(1'b0, "R8 unexpected beat", 32'(memAddr), 0);
          else begin
            e = expQ.pop_front();
            chk(memAddr === e.addr, "R1/R6 addr", 32'(memAddr), 32'(e.addr));
            chk(memByteEn === e.be, "R2 byteEn", 32'(memByteEn), 32'(e.be));
            chk(memBurstStart === e.bstart, "R5 burstStart", 32'(memBurstStart), 32'(e.bstart));
            if (e.bstart) chk(memBurstBytes === e.bbytes, "R5 burstBytes", 32'(memBurstBytes), 32'(e.bbytes));
            chk(memWrite === e.wr, "R6 direction", 32'(memWrite), 32'(e.wr));
            if (e.wr) chk(memWdata === e.data, "R4/R2 write data", 32'(memWdata), 32'(e.data));
            else chk(rdValid && rdData === e.data, "R4/R2 read data", 32'(rdData), 32'(e.data));
            if (e.last) nextDone = 1'b1;
          end
        end
      end
      if (reqValid && reqReady && zeroPending) nextDone = 1'b1;
    end
    doneExp = nextDone;
  end

  task automatic doReq(input logic wr, input logic byp, input logic [15:0] a,
                       input logic [11:0] len, input logic [15:0] seed);
    logic [15:0] ea; logic [11:0] el, rem; int nb; beat_t e;
    ea = (a | baseAddr) & (byp ? 16'hFFFF : 16'hFFFE);
    el = byp ? len : (len & 12'hFFE);
    nb = (int'(el) + 1) / 2;
    for (int i = 0; i < 128; i++) srcData[i] = seed + 16'(i) * 16'h0203;
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b0, b1;
      rem = el - 12'(2 * i);
      e.addr = ea + 16'(2 * i);
      e.wr = wr;
      e.be = (rem == 12'd1) ? 2'b01 : 2'b11;
      e.bstart = (i == 0) || (wr && !byp && (i % 32 == 0));
      e.bbytes = (wr && !byp) ? ((rem > 12'd64) ? 12'd64 : rem) : el;
      e.last = (i == nb - 1);
      if (wr) e.data = byp ? srcData[i] : {srcData[i][7:0], srcData[i][15:8]};
      else begin
        b0 = mem[e.addr[8:0]]; b1 = mem[9'(e.addr[8:0] + 9'd1)];
        e.data = byp ? {b1, b0} : {b0, b1};
      end
      expQ.push_back(e);
    end
    zeroPending = (el == 0);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqBypass = byp; reqAddr = a; reqLen = len; srcClr = 1'b1;
    @(negedge clk);
    reqValid = 1'b0; srcClr = 1'b0; zeroPending = 1'b0;
    while (!done) @(negedge clk);
    chk(expQ.size() == 0, "R9 all beats before done", 32'(expQ.size()), 0);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk(reqReady === 1'b1, "R10 reqReady", 32'(reqReady), 1);
    chk(memValid === 1'b0, "R10 memValid", 32'(memValid), 0);
    chk(done === 1'b0, "R10 done", 32'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    baseAddr = 16'h0100;
    doReq(1'b1, 1'b1, 16'h0023, 12'd5, 16'h1A2B);    // R2 bypass, odd addr and length
    doReq(1'b1, 1'b0, 16'h0011, 12'd7, 16'h3344);    // R3 R4 swapped write aligned
    doReq(1'b0, 1'b0, 16'h0011, 12'd7, 16'h0);       // R4 swapped read back
    doReq(1'b0, 1'b1, 16'h0023, 12'd5, 16'h0);       // R2 bypass read, odd tail
    stallOn = 1'b1;
    doReq(1'b1, 1'b0, 16'h0010, 12'd150, 16'h5A01);  // R5 R7 chunked write with stalls
    doReq(1'b1, 1'b1, 16'h0040, 12'd100, 16'h7700);  // R5 single bypass burst
    doReq(1'b0, 1'b0, 16'h0010, 12'd70, 16'h0);      // R5 single read burst
    stallOn = 1'b0;
    doReq(1'b1, 1'b0, 16'h0031, 12'd1, 16'h0);       // R8 length rounds to zero
    doReq(1'b0, 1'b1, 16'h0000, 12'd0, 16'h0);       // R8 bypass zero length
    baseAddr = 16'h0180;
    doReq(1'b0, 1'b1, 16'h0081, 12'd2, 16'h0);       // R1 OR (0x181), not add (0x201)
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++; checks++;
    $display("FAIL R9 watchdog actual=hang expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule